// File: doc/BRIEF.md
# Shared Interrupt Level Aggregator

This block collects level-sensitive interrupt requests from a set of functions and folds them onto four shared interrupt lines. Every function has four request pins. Each pin is steered to one of the four lines by a rotation that depends on the function's device number. Some functions sit behind a chain of bridges, and each bridge in that chain rotates the line once more by its own device number.

Every line has a counter that holds how many pins currently hold a request on it, and the line is driven high while that counter is non-zero. The block keeps a copy of each pin's last sampled level. It compares the pins against that copy on every clock, and only the differences change the counters. A pin that holds its level therefore costs nothing. Increments and decrements that fall in the same cycle are netted against one another before the counter is written.

Parameters set the number of functions, how many of them attach directly to the root bus, the number of bridge levels above the remaining functions, and the device number of the first bridge.

Top module: `irq_share_agg`

## Requirements
- R1: Each function owns four pins. Pin p of function f is bit `f*4+p` of `irq_pins`. Every pin is sampled on every rising clock edge.
- R2: A pin whose sampled level equals its stored level leaves every line counter unchanged.
- R3: When a pin rises, the counter of its mapped line increments. When a pin falls, that counter decrements. The counters always sum to the number of pins that are stored high.
- R4: `irq_out[l]` is 1 exactly when the counter of line l is non-zero. The counter value appears on `line_count[l*CNT_W +: CNT_W]`.
- R5: A function f below `NUM_DIRECT` sits on the root bus with device number f. Its pin p drives line `(p + f) mod 4`.
- R6: A function f at or above `NUM_DIRECT` sits behind `BRIDGE_LEVELS` bridges and has device number `f - NUM_DIRECT`. Bridge level k has device number `BRIDGE_DEV_BASE + k`. The pin's line is `(p + f - NUM_DIRECT)` plus the device number of every bridge level, taken mod 4.
- R7: All pin changes in one cycle are applied to their counters together, whatever mix of lines and directions they involve.
- R8: A synchronous active-low reset clears all stored levels and all counters, so every output is low during reset and one cycle after its release if no pin is high.
- R9: No counter ever exceeds the total number of pins, and no counter is decremented below zero.
- R10: Outputs reflect the pins sampled at the most recent rising edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pins | input | NUM_FUNCS*4 | Level request pins, function-major |
| irq_out | output | 4 | Shared interrupt lines |
| line_count | output | 4*CNT_W | Per-line asserted-pin counters |

## Verification
Every result is due one rising edge after the pins are presented, because both the stored levels and the counters are registers written on that same edge. The bench therefore changes the pins on the falling edge. It compares the counters and lines on the following falling edge against a model built only from the pins it applied. That model counts, for each line, the high pins that route there through the root or bridged rule. During reset and on the edge where reset is released, the expected values are zero, and they track the pins from the next edge onward.

// File: rtl/irq_share_pkg.sv
// Package: shared constants and the pin-to-line routing rule.
// Assumes four shared lines and four pins per function.
package irq_share_pkg;
    localparam int NUM_LINES = 4;
    localparam int PINS_PER_FUNC = 4;

    // Route pin p of function f to a root line (R5, R6).
    function automatic int route_line(input int f, input int p,
                                      input int num_direct,
                                      input int levels,
                                      input int bridge_base);
        int acc;
        if (f < num_direct) begin
            acc = p + f;
        end else begin
            acc = p + (f - num_direct);
            for (int k = 0; k < levels; k++) begin
                acc = acc + bridge_base + k;
            end
        end
        return acc % NUM_LINES;
    endfunction
endpackage

// File: rtl/irq_level_tracker.sv
// Level tracker: holds the last sampled level of every pin and flags
// rises and falls against it. Assumes pins are synchronous to clk.
module irq_level_tracker #(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);
    // Store the sampled pin levels, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= pins;
    end

    // Flag differences between the pins and the stored copy.
    always_comb begin
        rise = pins & ~level;
        fall = ~pins & level;
    end

    // An unchanged pin vector leaves the stored copy stable (R2).
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == level) |=> $stable(level));

    // The stored copy follows the pins one edge later (R10).
    assert_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (level == $past(pins)));
endmodule

// File: rtl/irq_line_counter.sv
// Line counter: nets rising and falling pins that target one line and
// keeps the count of asserted pins. Assumes the masks come from the tracker.
module irq_line_counter #(
    parameter int NPINS = 24,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] inc_mask,
    input  logic [NPINS-1:0] dec_mask,
    output logic [CNT_W-1:0] count,
    output logic             line_on
);
    logic [CNT_W:0] n_inc;
    logic [CNT_W:0] n_dec;

    // Population count of incoming rises and falls (R7).
    always_comb begin
        n_inc = '0;
        n_dec = '0;
        for (int i = 0; i < NPINS; i++) begin
            n_inc = n_inc + {{CNT_W{1'b0}}, inc_mask[i]};
            n_dec = n_dec + {{CNT_W{1'b0}}, dec_mask[i]};
        end
    end

    // Apply the net change to the counter, cleared by reset (R3, R8).
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= CNT_W'(({1'b0, count} + n_inc) - n_dec);
    end

    // Drive the line while any pin is counted (R4).
    always_comb line_on = (count != '0);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, count} <= (CNT_W+1)'(NPINS)));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, count} + n_inc >= n_dec));

    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (n_inc == '0 && n_dec == '0) |=> $stable(count));
endmodule

// File: rtl/irq_share_agg.sv
// Top: tracks the levels of all function pins, routes each pin to a shared
// line by the device-number rotation (with bridge levels), and counts
// asserted pins per line. Assumes synchronous pins and reset.
module irq_share_agg #(
    parameter int NUM_FUNCS       = 6,
    parameter int NUM_DIRECT      = 4,
    parameter int BRIDGE_LEVELS   = 2,
    parameter int BRIDGE_DEV_BASE = 1,
    localparam int NPINS          = NUM_FUNCS * irq_share_pkg::PINS_PER_FUNC,
    localparam int CNT_W          = $clog2(NPINS + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NPINS-1:0]                      irq_pins,
    output logic [irq_share_pkg::NUM_LINES-1:0]   irq_out,
    output logic [irq_share_pkg::NUM_LINES*CNT_W-1:0] line_count
);
    import irq_share_pkg::*;

    logic [NPINS-1:0] level, rise, fall;
    logic [NPINS-1:0] inc_mask [NUM_LINES];
    logic [NPINS-1:0] dec_mask [NUM_LINES];
    logic [CNT_W-1:0] cnt      [NUM_LINES];

    irq_level_tracker #(.NPINS(NPINS)) u_track (
        .clk(clk), .rst_n(rst_n), .pins(irq_pins),
        .level(level), .rise(rise), .fall(fall)
    );

    // Steer every pin's rise and fall onto its routed line (R5, R6).
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            localparam int ROUTE = route_line(i / PINS_PER_FUNC,
                                              i % PINS_PER_FUNC,
                                              NUM_DIRECT, BRIDGE_LEVELS,
                                              BRIDGE_DEV_BASE);
            if (ROUTE == l) begin : g_hit
                assign inc_mask[l][i] = rise[i];
                assign dec_mask[l][i] = fall[i];
            end else begin : g_miss
                assign inc_mask[l][i] = 1'b0;
                assign dec_mask[l][i] = 1'b0;
            end
        end

        irq_line_counter #(.NPINS(NPINS), .CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc_mask(inc_mask[l]), .dec_mask(dec_mask[l]),
            .count(cnt[l]), .line_on(irq_out[l])
        );
        assign line_count[l*CNT_W +: CNT_W] = cnt[l];
    end

    // Counter total across lines, used to check against the stored levels.
    logic [CNT_W+1:0] cnt_total;
    always_comb begin
        cnt_total = '0;
        for (int l = 0; l < NUM_LINES; l++) cnt_total = cnt_total + (CNT_W+2)'(cnt[l]);
    end

    assert_sum_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt_total == (CNT_W+2)'($countones(level))));

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));
endmodule

// File: tb/irq_share_agg_tb.sv
module irq_share_agg_tb;
    localparam int NUM_FUNCS = 6;
    localparam int NUM_DIRECT = 4;
    localparam int BLEV = 2;
    localparam int BBASE = 1;
    localparam int NPINS = NUM_FUNCS * 4;
    localparam int CNT_W = $clog2(NPINS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPINS-1:0] irq_pins = '0;
    logic [3:0] irq_out;
    logic [4*CNT_W-1:0] line_count;

    int checks = 0;
    int errors = 0;
    bit in_rst = 1'b1;

    always #4 clk = ~clk;

    irq_share_agg #(.NUM_FUNCS(NUM_FUNCS), .NUM_DIRECT(NUM_DIRECT),
                    .BRIDGE_LEVELS(BLEV), .BRIDGE_DEV_BASE(BBASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins),
        .irq_out(irq_out), .line_count(line_count));

    // Bench routing rule from R5/R6.
    function automatic int tb_line(int f, int p);
        int d;
        if (f < NUM_DIRECT) return (p + f) % 4;
        d = p + f - NUM_DIRECT;
        for (int k = 0; k < BLEV; k++) d += BBASE + k;
        return d % 4;
    endfunction

    function automatic int tb_count(int l, logic [NPINS-1:0] v);
        int n = 0;
        for (int i = 0; i < NPINS; i++)
            if (v[i] && tb_line(i / 4, i % 4) == l) n++;
        return n;
    endfunction

    task automatic check(string tag);
        logic [3:0] eo;
        logic [4*CNT_W-1:0] ec;
        for (int l = 0; l < 4; l++) begin
            int n = in_rst ? 0 : tb_count(l, irq_pins);
            ec[l*CNT_W +: CNT_W] = CNT_W'(n);
            eo[l] = (n != 0);
        end
        checks++;
        if (line_count !== ec) begin
            errors++;
            $display("FAIL %s line_count actual %h expected %h", tag, line_count, ec);
        end
        checks++;
        if (irq_out !== eo) begin
            errors++;
            $display("FAIL %s irq_out actual %b expected %b", tag, irq_out, eo);
        end
    endtask

    // Drive on the falling edge, check one rising edge later (R10).
    task automatic step(logic [NPINS-1:0] v, string tag);
        irq_pins = v;
        @(negedge clk);
        check(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NPINS-1:0] v;
        void'($urandom(32'h1234));
        @(negedge clk);
        // R8: reset clears everything, even with pins high.
        irq_pins = '1;
        @(negedge clk);
        check("R8 in reset");
        rst_n = 1'b1;
        irq_pins = '0;
        @(negedge clk);
        in_rst = 1'b0;
        check("R8 after release");
        // R5: function 1 pin 2 -> line 3.
        v = '0; v[1*4+2] = 1'b1;
        step(v, "R5 root route");
        // R6: function 4 pin 0 -> line 3, function 5 pin 1 -> line 1.
        v = '0; v[4*4+0] = 1'b1;
        step(v, "R6 bridged f4");
        v = '0; v[5*4+1] = 1'b1;
        step(v, "R6 bridged f5");
        // R2: hold a pattern, counts stay.
        v = 24'h0F0A53;
        step(v, "R1 pattern");
        step(v, "R2 hold");
        step(v, "R2 hold again");
        // R7: everything rises at once then everything falls.
        step('1, "R7 all rise");
        step('1, "R9 max hold");
        step('0, "R7 all fall");
        // R7: mixed rise and fall on the same line.
        v = '0; v[0] = 1'b1;
        step(v, "R3 rise");
        v = '0; v[1*4+3] = 1'b1;
        step(v, "R7 swap same line");
        // R4: line drops when last pin falls.
        step('0, "R4 line low");
        // Random stimulus.
        for (int it = 0; it < 400; it++) begin
            v = irq_pins;
            for (int b = 0; b < NPINS; b++)
                if (($urandom % 5) == 0) v[b] = ~v[b];
            step(v, "R3 random");
        end
        // R8: reset mid-run with pins high.
        irq_pins = '1;
        rst_n = 1'b0;
        @(negedge clk);
        in_rst = 1'b1;
        check("R8 mid reset");
        rst_n = 1'b1;
        @(negedge clk);
        in_rst = 1'b0;
        check("R8 recover");
        step('0, "R4 final low");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule